// File: doc/BRIEF.md
# Link Liveness Timeout Monitor

This block watches a serial link that is up and trained (the L0 state) for signs of life from the far end. It runs two silence detectors. The first listens only to received flow-control update strobes. When none arrives for a full 128 µs window, it raises a one-cycle request to retrain the link. The second listens to flow-control updates and to received SKP sequences. When neither arrives for the same window, it raises a one-cycle flag saying that the partner's transmitter has gone electrically idle.

Each detector builds its window from a microsecond unit. A clock divider derives that unit, and a parameter sets the clock cycles per microsecond. A fast-training input shortens the window by a factor of 500 so that simulations of the full link finish quickly. The flow-control detector is silenced by its own disable input. It is also silenced whenever the partner has advertised unlimited credit for every header and payload type. The idle detector has a separate disable input. Decoding the link packets and moving the link state machine are done by neighbouring blocks, which drive the strobes and consume the two pulses.

Top module: `link_liveness_monitor`

## Requirements
- R1: During reset and on the first cycle after it, `retrain_req` and `idle_inferred` are both 0.
- R2: With `fast_train` = 0, a flow-control update accepted on clock edge E with no further update makes `retrain_req` high for exactly the cycle after edge E + TIMEOUT_US*CLK_PER_US. With the default parameters this is 16000 cycles.
- R3: Only a flow-control update restarts the retrain window. A SKP strobe leaves it running.
- R4: The idle window restarts on a flow-control update or on a SKP strobe. When it is left to run out, `idle_inferred` pulses with the same timing as in R2 and R8, measured from the last restart.
- R5: While `inf_credit_all` = 1, `retrain_req` stays 0. The idle detector is not affected.
- R6: While `fc_timeout_off` = 1, `retrain_req` stays 0. The idle detector is not affected.
- R7: While `idle_infer_off` = 1, `idle_inferred` stays 0. The retrain detector is not affected.
- R8: With `fast_train` = 1, the window lasts ceil(TIMEOUT_US*CLK_PER_US/FAST_DIV) cycles. With the default parameters this is 32 cycles.
- R9: While `link_in_l0` = 0, both windows are held at zero and no pulse is produced. The edge on which `link_in_l0` is first seen high restarts both windows.
- R10: Each output is a single-cycle pulse. After it fires, a detector stays silent until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_in_l0 | input | 1 | Link is in the trained active state |
| fc_update_evt | input | 1 | One-cycle strobe per received flow-control update |
| skp_evt | input | 1 | One-cycle strobe per received SKP sequence |
| fc_timeout_off | input | 1 | Disables the retrain detector |
| idle_infer_off | input | 1 | Disables the idle detector |
| inf_credit_all | input | 1 | Partner advertises unlimited credit for all types |
| fast_train | input | 1 | Shortens both windows by FAST_DIV |
| retrain_req | output | 1 | One-cycle retrain request |
| idle_inferred | output | 1 | One-cycle inferred-idle pulse |

## Verification
The bound checker tests the following on every cycle:
- Neither pulse appears right after its own restart event, after a cycle outside L0, or after a cycle in which its disable or the infinite-credit input was set.
- Each pulse lasts exactly one cycle.

The exact length of the window in normal and fast mode can only be shown by the bench's timed scenarios. The same holds for the following:
- a SKP strobe leaves the retrain window running,
- a detector stays silent after it has fired,
- the window restarts when the link re-enters L0.

// File: rtl/liveness_pkg.sv
package liveness_pkg;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CH_FC   = 0;
  localparam int unsigned CH_IDLE = 1;

  // Cycles that make up one counting unit of a silence window.
  function automatic int unsigned unit_cycles(input bit fast, input int unsigned clk_per_us);
    return fast ? 1 : clk_per_us;
  endfunction

  // Number of units in one silence window.
  function automatic int unsigned limit_units(input bit fast, input int unsigned clk_per_us,
                                              input int unsigned timeout_us, input int unsigned fast_div);
    int unsigned v;
    if (!fast) return timeout_us;
    v = (timeout_us * clk_per_us + fast_div - 1) / fast_div;
    return (v == 0) ? 1 : v;
  endfunction
endpackage

// File: rtl/unit_divider.sv
module unit_divider #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [DW-1:0] period,
  output logic          unit_done
);
  logic [DW-1:0] div_q;

  assign unit_done = run && !restart && (div_q == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (restart || !run)   div_q <= '0;
    else if (unit_done)         div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/silence_timer.sv
module silence_timer
  import liveness_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 125,
  parameter int unsigned TIMEOUT_US = 128,
  parameter int unsigned FAST_DIV   = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic fast,
  output logic unit_tick,
  output logic expire
);
  localparam int unsigned LIM_NORM = limit_units(1'b0, CLK_PER_US, TIMEOUT_US, FAST_DIV);
  localparam int unsigned LIM_FAST = limit_units(1'b1, CLK_PER_US, TIMEOUT_US, FAST_DIV);
  localparam int unsigned LIM_MAX  = (LIM_NORM > LIM_FAST) ? LIM_NORM : LIM_FAST;
  localparam int unsigned UW       = $clog2(LIM_MAX + 1);
  localparam int unsigned DW       = $clog2(CLK_PER_US + 1);
  localparam int unsigned PER_NORM = unit_cycles(1'b0, CLK_PER_US);
  localparam int unsigned PER_FAST = unit_cycles(1'b1, CLK_PER_US);

  logic [DW-1:0] period;
  logic [UW-1:0] limit;
  logic [UW-1:0] units_q;
  logic          fired_q;
  logic          hit;

  assign period = fast ? DW'(PER_FAST) : DW'(PER_NORM);
  assign limit  = fast ? UW'(LIM_FAST) : UW'(LIM_NORM);

  unit_divider #(.DW(DW)) i_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (active && !fired_q),
    .restart   (restart),
    .period    (period),
    .unit_done (unit_tick)
  );

  assign hit = unit_tick && (units_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q <= '0;
      fired_q <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!active || restart) begin
        units_q <= '0;
        fired_q <= 1'b0;
      end else if (hit) begin
        units_q <= '0;
        fired_q <= 1'b1;
        expire  <= 1'b1;
      end else if (unit_tick) begin
        units_q <= units_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_liveness_monitor.sv
module link_liveness_monitor
  import liveness_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 125,
  parameter int unsigned TIMEOUT_US = 128,
  parameter int unsigned FAST_DIV   = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in_l0,
  input  logic fc_update_evt,
  input  logic skp_evt,
  input  logic fc_timeout_off,
  input  logic idle_infer_off,
  input  logic inf_credit_all,
  input  logic fast_train,
  output logic retrain_req,
  output logic idle_inferred
);
  logic              l0_q;
  logic              l0_entry;
  logic [NUM_CH-1:0] ch_event;
  logic [NUM_CH-1:0] ch_active;
  logic [NUM_CH-1:0] ch_restart;
  logic [NUM_CH-1:0] ch_tick;
  logic [NUM_CH-1:0] ch_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) l0_q <= 1'b0;
    else        l0_q <= link_in_l0;
  end

  assign l0_entry = link_in_l0 && !l0_q;

  assign ch_event[CH_FC]    = fc_update_evt;
  assign ch_event[CH_IDLE]  = fc_update_evt || skp_evt;
  assign ch_active[CH_FC]   = link_in_l0 && !fc_timeout_off && !inf_credit_all;
  assign ch_active[CH_IDLE] = link_in_l0 && !idle_infer_off;
  assign ch_restart         = ch_event | {NUM_CH{l0_entry}};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    silence_timer #(
      .CLK_PER_US (CLK_PER_US),
      .TIMEOUT_US (TIMEOUT_US),
      .FAST_DIV   (FAST_DIV)
    ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (ch_active[g]),
      .restart   (ch_restart[g]),
      .fast      (fast_train),
      .unit_tick (ch_tick[g]),
      .expire    (ch_expire[g])
    );
  end

  assign retrain_req   = ch_expire[CH_FC];
  assign idle_inferred = ch_expire[CH_IDLE];
endmodule

// File: rtl/liveness_checker.sv
module liveness_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       link_in_l0,
  input logic       fc_update_evt,
  input logic       skp_evt,
  input logic       fc_timeout_off,
  input logic       idle_infer_off,
  input logic       inf_credit_all,
  input logic       retrain_req,
  input logic       idle_inferred,
  input logic [1:0] ch_restart
);
  AST_RETRAIN_IN_L0: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req |-> $past(link_in_l0)); // R9
  AST_IDLE_IN_L0: assert property (@(posedge clk) disable iff (!rst_n)
    idle_inferred |-> $past(link_in_l0)); // R9
  AST_RETRAIN_NOT_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req |-> !$past(fc_update_evt)); // R3
  AST_IDLE_NOT_AFTER_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    idle_inferred |-> !$past(fc_update_evt || skp_evt)); // R4
  AST_NO_FIRE_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_req || idle_inferred) |-> !$past(ch_restart == 2'b11)); // R4
  AST_CREDIT_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req |-> !$past(inf_credit_all)); // R5
  AST_FC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req |-> !$past(fc_timeout_off)); // R6
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    idle_inferred |-> !$past(idle_infer_off)); // R7
  AST_RETRAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req |=> !retrain_req); // R10
  AST_IDLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_inferred |=> !idle_inferred); // R10
endmodule

bind link_liveness_monitor liveness_checker i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .link_in_l0     (link_in_l0),
  .fc_update_evt  (fc_update_evt),
  .skp_evt        (skp_evt),
  .fc_timeout_off (fc_timeout_off),
  .idle_infer_off (idle_infer_off),
  .inf_credit_all (inf_credit_all),
  .retrain_req    (retrain_req),
  .idle_inferred  (idle_inferred),
  .ch_restart     (ch_restart)
);

// File: tb/test_link_liveness_monitor.sv
module test_link_liveness_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int N_NORM     = 128 * 125;
  localparam int N_FAST     = (N_NORM + 499) / 500;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n, link_in_l0, fc_update_evt, skp_evt;
  logic fc_timeout_off, idle_infer_off, inf_credit_all, fast_train;
  logic retrain_req, idle_inferred;
  int checks = 0, fails = 0, cnt_r = 0, cnt_i = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_liveness_monitor i_link_liveness_monitor (
    .clk(clk), .rst_n(rst_n), .link_in_l0(link_in_l0), .fc_update_evt(fc_update_evt),
    .skp_evt(skp_evt), .fc_timeout_off(fc_timeout_off), .idle_infer_off(idle_infer_off),
    .inf_credit_all(inf_credit_all), .fast_train(fast_train),
    .retrain_req(retrain_req), .idle_inferred(idle_inferred));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (retrain_req)   cnt_r++;
      if (idle_inferred) cnt_i++;
    end
  endtask

  task automatic clr();
    cnt_r = 0; cnt_i = 0;
  endtask

  task automatic kick_fc();
    fc_update_evt = 1'b1; @(negedge clk); fc_update_evt = 1'b0;
  endtask

  task automatic kick_skp();
    skp_evt = 1'b1; @(negedge clk); skp_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; link_in_l0 = 1'b0; fc_update_evt = 1'b0; skp_evt = 1'b0;
    fc_timeout_off = 1'b0; idle_infer_off = 1'b0; inf_credit_all = 1'b0; fast_train = 1'b0;
    run(5);
    chk(!retrain_req && !idle_inferred, "R1", "outputs in reset", int'(retrain_req) + int'(idle_inferred), 0);
    rst_n = 1'b1; clr(); run(1);
    chk(cnt_r == 0 && cnt_i == 0, "R1", "outputs after reset", cnt_r + cnt_i, 0);
    run(50);
    chk(cnt_r == 0 && cnt_i == 0, "R9", "pulses outside L0", cnt_r + cnt_i, 0);
  endtask

  task automatic t_normal();
    fast_train = 1'b0; link_in_l0 = 1'b1; run(2);
    kick_fc(); clr();
    run(N_NORM - 1);
    chk(cnt_r == 0, "R2", "retrain before window end", cnt_r, 0);
    run(1);
    chk(retrain_req == 1'b1, "R2", "retrain at window end", int'(retrain_req), 1);
    chk(idle_inferred == 1'b1, "R4", "idle at window end", int'(idle_inferred), 1);
  endtask

  task automatic t_fast();
    fast_train = 1'b1; kick_fc(); clr();
    run(N_FAST - 1);
    chk(cnt_r == 0, "R8", "fast retrain early", cnt_r, 0);
    run(1);
    chk(retrain_req == 1'b1, "R8", "fast retrain at end", int'(retrain_req), 1);
    run(60);
    chk(cnt_r == 1, "R10", "retrain pulses after firing", cnt_r, 1);
    chk(cnt_i == 1, "R10", "idle pulses after firing", cnt_i, 1);
  endtask

  task automatic t_restart();
    kick_fc(); clr(); run(19); kick_skp();
    run(N_FAST - 21);
    chk(cnt_r == 0, "R3", "retrain early after skp", cnt_r, 0);
    run(1);
    chk(retrain_req == 1'b1, "R3", "skp must not restart retrain", int'(retrain_req), 1);
    run(19);
    chk(cnt_i == 0, "R4", "idle early after skp restart", cnt_i, 0);
    run(1);
    chk(idle_inferred == 1'b1, "R4", "idle timed from skp", int'(idle_inferred), 1);
    kick_fc(); run(19); kick_fc(); clr();
    run(N_FAST - 1);
    chk(cnt_r == 0, "R3", "retrain early after second update", cnt_r, 0);
    run(1);
    chk(retrain_req == 1'b1, "R3", "retrain timed from second update", int'(retrain_req), 1);
  endtask

  task automatic t_suppress();
    inf_credit_all = 1'b1; kick_fc(); clr(); run(60);
    chk(cnt_r == 0, "R5", "retrain with infinite credit", cnt_r, 0);
    chk(cnt_i == 1, "R5", "idle with infinite credit", cnt_i, 1);
    inf_credit_all = 1'b0;
    fc_timeout_off = 1'b1; kick_fc(); clr(); run(60);
    chk(cnt_r == 0, "R6", "retrain while disabled", cnt_r, 0);
    chk(cnt_i == 1, "R6", "idle while fc disabled", cnt_i, 1);
    fc_timeout_off = 1'b0;
    idle_infer_off = 1'b1; kick_fc(); clr(); run(60);
    chk(cnt_i == 0, "R7", "idle while disabled", cnt_i, 0);
    chk(cnt_r == 1, "R7", "retrain while idle disabled", cnt_r, 1);
    idle_infer_off = 1'b0;
  endtask

  task automatic t_l0_exit();
    kick_fc(); run(20); link_in_l0 = 1'b0; clr(); run(40);
    chk(cnt_r == 0 && cnt_i == 0, "R9", "pulses after leaving L0", cnt_r + cnt_i, 0);
    link_in_l0 = 1'b1; clr();
    run(N_FAST);
    chk(cnt_r == 0, "R9", "retrain early after L0 entry", cnt_r, 0);
    run(1);
    chk(retrain_req == 1'b1, "R9", "retrain timed from L0 entry", int'(retrain_req), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_fast();
    t_restart();
    t_suppress();
    t_l0_exit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule